// File: doc/BRIEF.md
# Fixed-Point Requantization Stage

This block takes a wide signed or unsigned intermediate value from an arithmetic operator and turns it into a narrower fixed-point number. It does this in two steps. First, quantization drops fractional bits, either by rounding or by truncation. Second, overflow handling drops integer bits, either by saturating or by wrapping. The block is separate from any adder or multiplier, so a single instance can serve results from several operations. Each operation picks its own modes through two per-beat mode inputs.

The input format has `IN_W` bits, of which `IN_FRAC` are fractional. The output format has `OUT_W` bits, of which `OUT_INT` are integer bits, with the sign bit counted among them. Input and output share the signedness given by the parameter `SIGNED`. A build-time option `REGISTERED` selects where the stage sits. With `REGISTERED = 0` it is chained, so the output follows the input in the same cycle. With `REGISTERED = 1` it is unchained: a register captures the input beat, and the result appears one cycle later.

Top module: `fixq_stage`

## Requirements
- R1: The output carries `OUT_W - OUT_INT` fractional bits. With the defaults (input Q8.8 signed, output 8 bits with 3 integer bits), the input code 256 (value 1.0) gives output code 32. Illegal parameter sets stop elaboration.
- R2: With `round_en = 0`, the dropped fractional bits are discarded toward minus infinity. For example, input −13 gives output −2 (code 0xFE) with the defaults.
- R3: With `round_en = 1`, half an output LSB is added before the bits are discarded, so ties go toward plus infinity. For example, input 4 gives 1 and input −4 gives 0.
- R4: With `sat_en = 0`, the output is the low `OUT_W` bits of the quantized value. With truncation, this equals input bits `[DROP+OUT_W-1:DROP]`, where `DROP = IN_FRAC - OUT_FRAC`.
- R5: With `sat_en = 1`, a value outside the output range is clamped. For signed output the limits are 0x7F and 0x80 (width 8). For unsigned output the limits are all zeros and all ones. Under truncation, saturation never changes the sign bit.
- R6: Quantization happens before overflow handling, so a carry from rounding can trigger saturation or wrapping. For example, input 1020 with rounding gives 0x7F under saturate and 0x80 under wrap.
- R7: Each valid beat uses the `round_en` and `sat_en` values sampled with it. Back-to-back beats may use different modes.
- R8: In the unchained configuration, `out_valid` and `out_data` follow `in_valid` by exactly one clock. After reset, `out_valid` is 0.
- R9: In the chained configuration, `out_valid` equals `in_valid`, and `out_data` is a combinational function of the current inputs.
- R10: In the unchained configuration, while `in_valid` is 0, `out_data` holds the result of the last valid beat. Data and mode inputs have no effect during this time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_data | input | IN_W | Wide intermediate result |
| round_en | input | 1 | Quantization mode: 0 truncate, 1 round |
| sat_en | input | 1 | Overflow mode: 0 wrap, 1 saturate |
| out_valid | output | 1 | Output beat valid |
| out_data | output | OUT_W | Requantized result |

## Verification
The bench drives each beat at a falling edge and checks the chained instance 1 ns later, because its result is due within the same cycle. The unchained instance captures the beat at the next rising edge, so its result is due one cycle after the stimulus. The bench checks it at the following falling edge, before the next beat is applied. During idle cycles, the same falling-edge sample checks that the unchained output still holds the last valid result. The checker module states the same timing: it uses `|=>` for the unchained configuration and same-cycle implication for the chained one.

// File: rtl/fxq_pkg.sv
`timescale 1ns/1ps
package fxq_pkg;

   // Per-beat operating mode carried alongside the data.
   typedef struct packed {
      logic rnd;   // 1: round half up, 0: truncate toward -inf
      logic sat;   // 1: clamp, 0: wrap
   } fxq_mode_t;

   function automatic int frac_of(input int width, input int int_bits);
      return width - int_bits;
   endfunction

   function automatic int drop_of(input int in_frac, input int out_frac);
      return in_frac - out_frac;
   endfunction

endpackage

// File: rtl/fxq_capture.sv
`timescale 1ns/1ps
module fxq_capture
   import fxq_pkg::*;
#(
   parameter int W          = 16,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         v_i,
   input  logic [W-1:0] d_i,
   input  fxq_mode_t    m_i,
   output logic         v_o,
   output logic [W-1:0] d_o,
   output fxq_mode_t    m_o
);

   generate
      if (REGISTERED) begin : g_reg
         // Valid tracks every cycle; payload only loads on a valid beat.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_o <= 1'b0;
               d_o <= '0;
               m_o <= '0;
            end else begin
               v_o <= v_i;
               if (v_i) begin
                  d_o <= d_i;
                  m_o <= m_i;
               end
            end
         end
      end else begin : g_comb
         logic unused_clkrst;
         assign unused_clkrst = clk ^ rst_n;
         assign v_o = v_i;
         assign d_o = d_i;
         assign m_o = m_i;
      end
   endgenerate

endmodule

// File: rtl/fxq_quantizer.sv
`timescale 1ns/1ps
module fxq_quantizer #(
   parameter int IN_W   = 16,
   parameter int DROP   = 3,
   parameter bit SIGNED = 1'b1,
   localparam int QW    = IN_W + 1 - DROP
) (
   input  logic [IN_W-1:0] d,
   input  logic            rnd,
   output logic [QW-1:0]   q
);

   logic ext_bit;
   assign ext_bit = SIGNED ? d[IN_W-1] : 1'b0;

   generate
      if (DROP == 0) begin : g_pass
         logic unused_rnd;
         assign unused_rnd = rnd;
         assign q = {ext_bit, d};
      end else begin : g_drop
         logic [IN_W:0]   ext;
         logic [IN_W:0]   half;
         logic [IN_W:0]   sum;
         logic [DROP-1:0] unused_lsbs;

         assign ext  = {ext_bit, d};
         assign half = (IN_W+1)'(rnd) << (DROP - 1);
         // One guard bit absorbs the rounding carry; taking the upper
         // bits of a two's-complement sum floors toward -infinity.
         assign sum  = ext + half;
         assign {q, unused_lsbs} = sum;
      end
   endgenerate

endmodule

// File: rtl/fxq_overflow.sv
`timescale 1ns/1ps
module fxq_overflow #(
   parameter int QW     = 14,
   parameter int OUT_W  = 8,
   parameter bit SIGNED = 1'b1,
   localparam int HEAD  = QW - OUT_W
) (
   input  logic [QW-1:0]    q,
   input  logic             sat,
   output logic [OUT_W-1:0] y
);

   logic             fits;
   logic             neg;
   logic [OUT_W-1:0] limit;

   generate
      if (SIGNED) begin : g_signed
         logic [HEAD:0] top;
         assign top   = q[QW-1:OUT_W-1];
         assign fits  = (&top) | ~(|top);
         assign neg   = q[QW-1];
         assign limit = neg ? {1'b1, {(OUT_W-1){1'b0}}}
                            : {1'b0, {(OUT_W-1){1'b1}}};
      end else begin : g_unsigned
         logic [HEAD-1:0] top;
         assign top   = q[QW-1:OUT_W];
         assign fits  = ~(|top);
         assign neg   = 1'b0;
         assign limit = {OUT_W{1'b1}};
      end
   endgenerate

   always_comb begin
      if (sat && !fits) y = limit;
      else              y = q[OUT_W-1:0];
   end

endmodule

// File: rtl/fixq_stage.sv
`timescale 1ns/1ps
module fixq_stage
   import fxq_pkg::*;
#(
   parameter int IN_W       = 16,
   parameter int IN_FRAC    = 8,
   parameter int OUT_W      = 8,
   parameter int OUT_INT    = 3,
   parameter bit SIGNED     = 1'b1,
   parameter bit REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   input  logic             round_en,
   input  logic             sat_en,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);

   localparam int IN_INT   = IN_W - IN_FRAC;
   localparam int OUT_FRAC = frac_of(OUT_W, OUT_INT);
   localparam int DROP     = drop_of(IN_FRAC, OUT_FRAC);
   localparam int QW       = IN_W + 1 - DROP;

   generate
      if (OUT_FRAC < 0 || OUT_INT < 1) begin : g_bad_out
         $error("fixq_stage: output integer width must be 1..OUT_W");
      end
      if (DROP < 0) begin : g_bad_frac
         $error("fixq_stage: output cannot carry more fraction bits than input");
      end
      if (OUT_INT > IN_INT) begin : g_bad_int
         $error("fixq_stage: output cannot carry more integer bits than input");
      end
      if (OUT_W < 2 || IN_W < 2) begin : g_bad_w
         $error("fixq_stage: widths must be at least 2");
      end
   endgenerate

   fxq_mode_t        mode_in, mode_s;
   logic             v_s;
   logic [IN_W-1:0]  d_s;
   logic [QW-1:0]    q_s;

   assign mode_in.rnd = round_en;
   assign mode_in.sat = sat_en;

   fxq_capture #(.W(IN_W), .REGISTERED(REGISTERED)) u_cap (
      .clk (clk),
      .rst_n (rst_n),
      .v_i (in_valid),
      .d_i (in_data),
      .m_i (mode_in),
      .v_o (v_s),
      .d_o (d_s),
      .m_o (mode_s)
   );

   fxq_quantizer #(.IN_W(IN_W), .DROP(DROP), .SIGNED(SIGNED)) u_quant (
      .d   (d_s),
      .rnd (mode_s.rnd),
      .q   (q_s)
   );

   fxq_overflow #(.QW(QW), .OUT_W(OUT_W), .SIGNED(SIGNED)) u_ovf (
      .q   (q_s),
      .sat (mode_s.sat),
      .y   (out_data)
   );

   assign out_valid = v_s;

endmodule

// File: rtl/fxq_checker.sv
`timescale 1ns/1ps
module fxq_checker #(
   parameter int IN_W       = 16,
   parameter int OUT_W      = 8,
   parameter int DROP       = 3,
   parameter bit SIGNED     = 1'b1,
   parameter bit REGISTERED = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [IN_W-1:0]  in_data,
   input logic             round_en,
   input logic             sat_en,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_data
);

   logic unused_chk;
   assign unused_chk = ^in_data;

   generate
      if (REGISTERED) begin : g_reg
         assert_valid_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
         assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_data));
         assert_wrap_trunc_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !round_en && !sat_en)
            |=> out_data == $past(in_data[DROP+OUT_W-1:DROP]));
         assert_sat_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (SIGNED && in_valid && sat_en && !round_en)
            |=> out_data[OUT_W-1] == $past(in_data[IN_W-1]));
      end else begin : g_comb
         assert_comb_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
         assert_comb_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !round_en && !sat_en)
            |-> out_data == in_data[DROP+OUT_W-1:DROP]);
         assert_comb_sat_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (SIGNED && in_valid && sat_en && !round_en)
            |-> out_data[OUT_W-1] == in_data[IN_W-1]);
      end
   endgenerate

endmodule

bind fixq_stage fxq_checker #(
   .IN_W       (IN_W),
   .OUT_W      (OUT_W),
   .DROP       (DROP),
   .SIGNED     (SIGNED),
   .REGISTERED (REGISTERED)
) u_fxq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .round_en  (round_en),
   .sat_en    (sat_en),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/tb_fixq_stage.sv
`timescale 1ns/1ps
module tb_fixq_stage;

   localparam int IW   = 16;
   localparam int IFR  = 8;
   localparam int OW   = 8;
   localparam int OI   = 3;
   localparam int OFR  = OW - OI;
   localparam int DROP = IFR - OFR;
   localparam int HALF = 1 << (DROP - 1);
   localparam int QMAX = (1 << (OW - 1)) - 1;
   localparam int QMIN = -(1 << (OW - 1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic          in_valid = 1'b0;
   logic [IW-1:0] in_data  = '0;
   logic          round_en = 1'b0;
   logic          sat_en   = 1'b0;
   logic          reg_v, comb_v;
   logic [OW-1:0] reg_d, comb_d;

   fixq_stage #(.IN_W(IW), .IN_FRAC(IFR), .OUT_W(OW), .OUT_INT(OI),
                .SIGNED(1'b1), .REGISTERED(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .round_en(round_en), .sat_en(sat_en), .out_valid(reg_v), .out_data(reg_d));

   fixq_stage #(.IN_W(IW), .IN_FRAC(IFR), .OUT_W(OW), .OUT_INT(OI),
                .SIGNED(1'b1), .REGISTERED(1'b0)) dut_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .round_en(round_en), .sat_en(sat_en), .out_valid(comb_v), .out_data(comb_d));

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   bit pend_v = 1'b0;
   logic [OW-1:0] pend_exp = '0;
   string pend_tag = "";
   bit have_last = 1'b0;
   logic [OW-1:0] last_exp = '0;

   // Reference: wide integer arithmetic straight from R2..R6.
   function automatic logic [OW-1:0] model(input int x, input bit rnd, input bit sat);
      int q;
      q = (x + (rnd ? HALF : 0)) >>> DROP;
      if (sat) begin
         if (q > QMAX) q = QMAX;
         if (q < QMIN) q = QMIN;
      end
      return q[OW-1:0];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // One cycle: check the unchained result of the previous beat, drive a
   // new beat, then check the chained result of this beat.
   task automatic beat(input bit v, input int x, input bit rnd, input bit sat,
                       input string tag);
      @(negedge clk);
      check({pend_tag, " R8 valid"}, 32'(reg_v), 32'(pend_v));
      if (pend_v) check({pend_tag, " R8 data"}, 32'(reg_d), 32'(pend_exp));
      else if (have_last) check({pend_tag, " R10 hold"}, 32'(reg_d), 32'(last_exp));
      in_valid = v;
      in_data  = x[IW-1:0];
      round_en = rnd;
      sat_en   = sat;
      #1;
      check({tag, " R9 valid"}, 32'(comb_v), 32'(v));
      if (v) check({tag, " R9 data"}, 32'(comb_d), 32'(model(x, rnd, sat)));
      pend_v   = v;
      pend_tag = tag;
      if (v) begin
         pend_exp  = model(x, rnd, sat);
         last_exp  = pend_exp;
         have_last = 1'b1;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 reset valid", 32'(reg_v), 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_format();
      beat(1, 256, 0, 1, "R1 one");
      check("R1 code of 1.0", 32'(model(256, 0, 1)), 32'd32);
      beat(1, -256, 0, 1, "R1 minus one");
      beat(0, 0, 0, 0, "R1 flush");
   endtask

   task automatic t_trunc();
      beat(1, 13, 0, 1, "R2 pos");
      beat(1, -13, 0, 1, "R2 neg");
      check("R2 floor -13", 32'(model(-13, 0, 1)), 32'hFE);
      beat(1, -1, 0, 1, "R2 minus lsb");
      beat(1, 7, 0, 0, "R2 below lsb");
      beat(0, 0, 0, 0, "R2 flush");
   endtask

   task automatic t_round();
      beat(1, 4, 1, 1, "R3 tie pos");
      beat(1, -4, 1, 1, "R3 tie neg");
      beat(1, 11, 1, 1, "R3 up");
      beat(1, -12, 1, 0, "R3 neg tie wrap");
      beat(0, 0, 0, 0, "R3 flush");
   endtask

   task automatic t_wrap();
      beat(1, 1100, 0, 0, "R4 wrap pos");
      beat(1, -2000, 0, 0, "R4 wrap neg");
      beat(1, 32767, 0, 0, "R4 wrap max");
      beat(0, 0, 0, 0, "R4 flush");
   endtask

   task automatic t_sat();
      beat(1, 1100, 0, 1, "R5 sat pos");
      beat(1, -2000, 0, 1, "R5 sat neg");
      beat(1, 32767, 1, 1, "R5 sat max");
      beat(1, -32768, 1, 1, "R5 sat min");
      beat(0, 0, 0, 0, "R5 flush");
   endtask

   task automatic t_order();
      beat(1, 1020, 1, 1, "R6 carry sat");
      check("R6 carry sat value", 32'(model(1020, 1, 1)), 32'h7F);
      beat(1, 1020, 1, 0, "R6 carry wrap");
      beat(1, 1020, 0, 1, "R6 no carry");
      beat(1, -1028, 0, 1, "R6 neg trunc sat");
      beat(1, -1028, 1, 1, "R6 neg round");
      beat(0, 0, 0, 0, "R6 flush");
   endtask

   task automatic t_mixed();
      for (int k = 0; k < 8; k++)
         beat(1, 1019 + k, k[0], k[1], "R7 mode per beat");
      beat(0, 0, 0, 0, "R7 flush");
   endtask

   task automatic t_hold();
      beat(1, 300, 1, 1, "R10 load");
      beat(0, -32768, 0, 0, "R10 idle a");
      beat(0, 32767, 1, 0, "R10 idle b");
      beat(0, 5, 1, 1, "R10 idle c");
   endtask

   task automatic t_random();
      for (int k = 0; k < 400; k++) begin
         int x;
         x = int'($urandom_range(65535)) - 32768;
         beat($urandom_range(3) != 0, x, $urandom_range(1) == 1,
              $urandom_range(1) == 1, "R7 random");
      end
      beat(0, 0, 0, 0, "R7 flush");
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_format();
      t_trunc();
      t_round();
      t_wrap();
      t_sat();
      t_order();
      t_mixed();
      t_hold();
      t_random();
      report();
   end

   initial begin
      #(8 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

endmodule